// File: doc/BRIEF.md
# DMA Channel Register Front-End

This block is the register face of a bank of DMA channels. It sits between a 32-bit register bus and the channel engines. Each channel owns its own 8 KiB address window. The upper address bits above bit 12 pick the channel, and the low 13 bits pick a register inside that window.

The block holds the following per channel:
- four descriptor pointer registers;
- a configuration word;
- the last command and stream-command values;
- the interrupt state.

It composes a status word from the state, end-of-list flag and command-source value that the engine reports. It turns command and stream-command writes into one-cycle request pulses for the engine. It also runs the pending, mask and acknowledge logic behind one interrupt line per channel.

Fetching descriptors and moving data belong to the engine and are not part of this block. Only full 32-bit accesses exist. A read is combinational: `rdata` reflects the register chosen by `addr` while `rd_en` is high. A write takes effect at the rising clock edge where `wr_en` is high.

Top module: `dma_regfront`

## Requirements
- R1: The channel index is `addr >> 13`, and the register offset is `addr[12:0]`. A write to a channel index at or above `NUM_CH` changes nothing, and a read from such an index returns 0.
- R2: The data pointer (offset 0x58), buffer pointer (0x5C), group pointer (0x60) and group-down pointer (0x7C) are 32-bit read/write registers. Each drives its own pointer output for the channel.
- R3: The configuration register at 0x84 reads back as written. Its bit 0 drives `cfg_en`, and its bit 1 drives `cfg_stop`.
- R4: A read of 0x88 returns the engine state code in bits 2:0 (0 reset, 2 stopped, 4 running), the end-of-list flag in bit 5 and the command-source value from bit 8 upward. Writes to 0x88 have no effect.
- R5: A write to 0x80 stores the value, which reads back. It raises `req_cont` for that channel during exactly the one cycle after the write edge.
- R6: A write to 0x9C stores the value, and only bits 9:0 are decoded. A write with bit 8 or bit 6 set pulses `req_load_d`. If bit 5 is also set, the same write pulses `req_start`. A write with bit 9 set pulses `req_load_c`. Each pulse lasts one cycle, in the cycle after the write edge.
- R7: Bit k of `irq_set` sets raw pending bit k (read at 0x94). A write to the acknowledge register 0x90 clears every raw bit that is 1 in the written value. The acknowledge register always reads 0, so a write to the mask register 0x8C clears no raw bit.
- R8: If a set and an acknowledge hit the same raw bit in the same cycle, the bit ends up set.
- R9: The mask register at 0x8C reads back as written. Offset 0x98 reads raw AND mask. The channel's `irq` output is high exactly when that masked value is nonzero.
- R10: A write to an offset that names no writable register (including 0x94 and 0x98) is ignored. A read from an offset that names no register returns 0.
- R11: After reset, every register reads 0, and all request pulses and interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address: channel index above bit 12, offset below |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| eng_state | input | 3*NUM_CH | Per-channel engine state code |
| eng_eol | input | NUM_CH | Per-channel end-of-list flag |
| eng_src | input | SRC_W*NUM_CH | Per-channel command-source value |
| irq_set | input | IRQ_W*NUM_CH | Per-bit raw interrupt set from the engine |
| ptr_data | output | 32*NUM_CH | Data descriptor pointers |
| ptr_buf | output | 32*NUM_CH | Buffer position pointers |
| ptr_grp | output | 32*NUM_CH | Group descriptor pointers |
| ptr_down | output | 32*NUM_CH | Group-down pointers |
| cfg_en | output | NUM_CH | Channel enable |
| cfg_stop | output | NUM_CH | Channel stop request |
| req_load_d | output | NUM_CH | Load-data-descriptor pulse |
| req_start | output | NUM_CH | Start pulse |
| req_load_c | output | NUM_CH | Load-context pulse |
| req_cont | output | NUM_CH | Continue pulse |
| irq | output | NUM_CH | Interrupt line per channel |

## Verification
The bench builds the block with `NUM_CH` = 3, which makes `ADDR_W` 15. Channel index 3 is then a legal address that names no channel, so the ignore and read-as-zero rule for missing channels can be driven directly. Three channels also let writes to one window be checked for leaks into its neighbours. `IRQ_W` = 8 and `SRC_W` = 8 place a full byte of command source at bits 15:8, so a value such as 0x5A shows whether the status fields are packed without overlap.

// File: rtl/dma_regfront_pkg.sv
package dma_regfront_pkg;

  localparam int WIN_BITS = 13;

  localparam logic [12:0] OFF_DATA_PTR = 13'h058;
  localparam logic [12:0] OFF_BUF_PTR  = 13'h05C;
  localparam logic [12:0] OFF_GRP_PTR  = 13'h060;
  localparam logic [12:0] OFF_DOWN_PTR = 13'h07C;
  localparam logic [12:0] OFF_CMD      = 13'h080;
  localparam logic [12:0] OFF_CFG      = 13'h084;
  localparam logic [12:0] OFF_STATUS   = 13'h088;
  localparam logic [12:0] OFF_MASK     = 13'h08C;
  localparam logic [12:0] OFF_ACK      = 13'h090;
  localparam logic [12:0] OFF_RAW      = 13'h094;
  localparam logic [12:0] OFF_MASKED   = 13'h098;
  localparam logic [12:0] OFF_STREAM   = 13'h09C;

  typedef struct packed {
    logic load_d;
    logic start;
    logic load_c;
  } strm_req_t;

  // Stream command: only the low ten bits carry meaning.
  function automatic strm_req_t strm_decode(input logic [31:0] v);
    strm_req_t r;
    logic [9:0] c;
    c        = v[9:0];
    r.load_d = |(c & 10'h140);
    r.start  = r.load_d & c[5];
    r.load_c = c[9];
    return r;
  endfunction

  // Status word: state in [2:0], end-of-list in [5], source from [8].
  function automatic logic [31:0] status_word(input logic [2:0] st,
                                              input logic eol,
                                              input logic [23:0] src);
    logic [31:0] w;
    w      = {src, 8'h00};
    w[2:0] = st;
    w[5]   = eol;
    return w;
  endfunction

  // Pending update: acknowledged bits drop, set bits win.
  function automatic logic [31:0] pend_next(input logic [31:0] raw,
                                            input logic [31:0] ack,
                                            input logic [31:0] set);
    return (raw & ~ack) | set;
  endfunction

endpackage

// File: rtl/dma_win_decode.sv
module dma_win_decode #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 14
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [12:0]       offset,
  output logic [NUM_CH-1:0] ch_sel
);
  localparam int CH_BITS = ADDR_W - dma_regfront_pkg::WIN_BITS;

  logic [CH_BITS-1:0] index;

  assign offset = addr[12:0];
  assign index  = addr[ADDR_W-1:dma_regfront_pkg::WIN_BITS];

  // An index with no channel behind it selects nothing.
  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    assign ch_sel[g] = (index == CH_BITS'(g));
  end
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit #(
  parameter int IRQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_bits,
  input  logic             ack_wr,
  input  logic             mask_wr,
  input  logic [IRQ_W-1:0] wr_bits,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] masked,
  output logic             irq
);
  import dma_regfront_pkg::*;

  logic [IRQ_W-1:0] ack_bits;
  logic [IRQ_W-1:0] raw_nx;
  logic             ready_q;

  // The acknowledge register holds a value only in its write cycle.
  assign ack_bits = ack_wr ? wr_bits : '0;
  assign raw_nx   = IRQ_W'(pend_next(32'(raw), 32'(ack_bits), 32'(set_bits)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw     <= '0;
      mask    <= '0;
      ready_q <= 1'b0;
    end else begin
      raw     <= raw_nx;
      ready_q <= 1'b1;
      if (mask_wr) mask <= wr_bits;
    end
  end

  assign masked = raw & mask;
  assign irq    = |masked;

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q |-> ((raw & $past(set_bits)) == $past(set_bits)));

  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && $past(ack_wr)) |->
      ((raw & $past(wr_bits & ~set_bits)) == '0));

  p_irq_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((mask != '0) && (raw != '0)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int IRQ_W = 8,
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [12:0]      offset,
  input  logic [31:0]      wdata,
  input  logic [2:0]       eng_state,
  input  logic             eng_eol,
  input  logic [SRC_W-1:0] eng_src,
  input  logic [IRQ_W-1:0] irq_set,
  output logic [31:0]      rd_val,
  output logic [31:0]      ptr_data,
  output logic [31:0]      ptr_buf,
  output logic [31:0]      ptr_grp,
  output logic [31:0]      ptr_down,
  output logic             cfg_en,
  output logic             cfg_stop,
  output logic             pls_load_d,
  output logic             pls_start,
  output logic             pls_load_c,
  output logic             pls_cont,
  output logic             irq
);
  import dma_regfront_pkg::*;

  logic [31:0] cfg_q, cmd_q, strm_q;
  logic        ready_q;

  // Named write events.
  logic wr_hit_data, wr_hit_buf, wr_hit_grp, wr_hit_down;
  logic wr_hit_cmd, wr_hit_cfg, wr_hit_mask, wr_hit_ack, wr_hit_strm;
  assign wr_hit_data = wr && (offset == OFF_DATA_PTR);
  assign wr_hit_buf  = wr && (offset == OFF_BUF_PTR);
  assign wr_hit_grp  = wr && (offset == OFF_GRP_PTR);
  assign wr_hit_down = wr && (offset == OFF_DOWN_PTR);
  assign wr_hit_cmd  = wr && (offset == OFF_CMD);
  assign wr_hit_cfg  = wr && (offset == OFF_CFG);
  assign wr_hit_mask = wr && (offset == OFF_MASK);
  assign wr_hit_ack  = wr && (offset == OFF_ACK);
  assign wr_hit_strm = wr && (offset == OFF_STREAM);

  strm_req_t strm_req;
  assign strm_req = strm_decode(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_data   <= '0;
      ptr_buf    <= '0;
      ptr_grp    <= '0;
      ptr_down   <= '0;
      cfg_q      <= '0;
      cmd_q      <= '0;
      strm_q     <= '0;
      pls_load_d <= 1'b0;
      pls_start  <= 1'b0;
      pls_load_c <= 1'b0;
      pls_cont   <= 1'b0;
      ready_q    <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (wr_hit_data) ptr_data <= wdata;
      if (wr_hit_buf)  ptr_buf  <= wdata;
      if (wr_hit_grp)  ptr_grp  <= wdata;
      if (wr_hit_down) ptr_down <= wdata;
      if (wr_hit_cfg)  cfg_q    <= wdata;
      if (wr_hit_cmd)  cmd_q    <= wdata;
      if (wr_hit_strm) strm_q   <= wdata;
      pls_cont   <= wr_hit_cmd;
      pls_load_d <= wr_hit_strm && strm_req.load_d;
      pls_start  <= wr_hit_strm && strm_req.start;
      pls_load_c <= wr_hit_strm && strm_req.load_c;
    end
  end

  assign cfg_en   = cfg_q[0];
  assign cfg_stop = cfg_q[1];

  logic [IRQ_W-1:0] raw, mask, masked;

  dma_irq_unit #(.IRQ_W(IRQ_W)) i_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_bits (irq_set),
    .ack_wr   (wr_hit_ack),
    .mask_wr  (wr_hit_mask),
    .wr_bits  (wdata[IRQ_W-1:0]),
    .raw      (raw),
    .mask     (mask),
    .masked   (masked),
    .irq      (irq)
  );

  always_comb begin
    unique case (offset)
      OFF_DATA_PTR: rd_val = ptr_data;
      OFF_BUF_PTR:  rd_val = ptr_buf;
      OFF_GRP_PTR:  rd_val = ptr_grp;
      OFF_DOWN_PTR: rd_val = ptr_down;
      OFF_CMD:      rd_val = cmd_q;
      OFF_CFG:      rd_val = cfg_q;
      OFF_STATUS:   rd_val = status_word(eng_state, eng_eol, 24'(eng_src));
      OFF_MASK:     rd_val = 32'(mask);
      OFF_RAW:      rd_val = 32'(raw);
      OFF_MASKED:   rd_val = 32'(masked);
      OFF_STREAM:   rd_val = strm_q;
      default:      rd_val = '0;
    endcase
  end

  p_start_with_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pls_start |-> pls_load_d);

  p_cont_follows_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && pls_cont) |-> $past(wr_hit_cmd));
endmodule

// File: rtl/dma_regfront.sv
module dma_regfront #(
  parameter int NUM_CH = 2,
  parameter int IRQ_W  = 8,
  parameter int SRC_W  = 8,
  parameter int ADDR_W = 13 + ((NUM_CH > 1) ? $clog2(NUM_CH) : 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  output logic [31:0]             rdata,
  input  logic [3*NUM_CH-1:0]     eng_state,
  input  logic [NUM_CH-1:0]       eng_eol,
  input  logic [SRC_W*NUM_CH-1:0] eng_src,
  input  logic [IRQ_W*NUM_CH-1:0] irq_set,
  output logic [32*NUM_CH-1:0]    ptr_data,
  output logic [32*NUM_CH-1:0]    ptr_buf,
  output logic [32*NUM_CH-1:0]    ptr_grp,
  output logic [32*NUM_CH-1:0]    ptr_down,
  output logic [NUM_CH-1:0]       cfg_en,
  output logic [NUM_CH-1:0]       cfg_stop,
  output logic [NUM_CH-1:0]       req_load_d,
  output logic [NUM_CH-1:0]       req_start,
  output logic [NUM_CH-1:0]       req_load_c,
  output logic [NUM_CH-1:0]       req_cont,
  output logic [NUM_CH-1:0]       irq
);
  logic [12:0]       offset;
  logic [NUM_CH-1:0] ch_sel;
  logic [31:0]       ch_rd [NUM_CH];

  dma_win_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_dec (
    .addr   (addr),
    .offset (offset),
    .ch_sel (ch_sel)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_chan_regs #(.IRQ_W(IRQ_W), .SRC_W(SRC_W)) i_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (wr_en && ch_sel[c]),
      .offset     (offset),
      .wdata      (wdata),
      .eng_state  (eng_state[3*c +: 3]),
      .eng_eol    (eng_eol[c]),
      .eng_src    (eng_src[SRC_W*c +: SRC_W]),
      .irq_set    (irq_set[IRQ_W*c +: IRQ_W]),
      .rd_val     (ch_rd[c]),
      .ptr_data   (ptr_data[32*c +: 32]),
      .ptr_buf    (ptr_buf[32*c +: 32]),
      .ptr_grp    (ptr_grp[32*c +: 32]),
      .ptr_down   (ptr_down[32*c +: 32]),
      .cfg_en     (cfg_en[c]),
      .cfg_stop   (cfg_stop[c]),
      .pls_load_d (req_load_d[c]),
      .pls_start  (req_start[c]),
      .pls_load_c (req_load_c[c]),
      .pls_cont   (req_cont[c]),
      .irq        (irq[c])
    );
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (rd_en && ch_sel[c]) rdata = rdata | ch_rd[c];
  end

  // R1: at most one channel window is ever selected.
  p_one_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_sel));
endmodule

// File: tb/test_dma_regfront.sv
`timescale 1ns/100ps
module test_dma_regfront;
  localparam int NCH = 3, IW = 8, SW = 8, AW = 15;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3*NCH-1:0] eng_state = '0;
  logic [NCH-1:0] eng_eol = '0;
  logic [SW*NCH-1:0] eng_src = '0;
  logic [IW*NCH-1:0] irq_set = '0;
  logic [32*NCH-1:0] ptr_data, ptr_buf, ptr_grp, ptr_down;
  logic [NCH-1:0] cfg_en, cfg_stop, req_load_d, req_start, req_load_c, req_cont, irq;

  always #2.5 clk = ~clk;

  dma_regfront #(.NUM_CH(NCH), .IRQ_W(IW), .SRC_W(SW)) i_dma_regfront (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .eng_state(eng_state), .eng_eol(eng_eol),
    .eng_src(eng_src), .irq_set(irq_set), .ptr_data(ptr_data),
    .ptr_buf(ptr_buf), .ptr_grp(ptr_grp), .ptr_down(ptr_down),
    .cfg_en(cfg_en), .cfg_stop(cfg_stop), .req_load_d(req_load_d),
    .req_start(req_start), .req_load_c(req_load_c), .req_cont(req_cont),
    .irq(irq));

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int ch, input logic [12:0] off, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = {ch[1:0], off}; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int ch, input logic [12:0] off, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = {ch[1:0], off};
    #1 d = rdata;
    rd_en = 1'b0;
  endtask

  // {is_read, channel, offset, data, requirement number}
  localparam int NV = 20;
  localparam logic [51:0] VEC [NV] = '{
    {1'b0, 2'd0, 13'h058, 32'h1000_0040, 4'd2},
    {1'b0, 2'd1, 13'h05C, 32'hA5A5_0004, 4'd2},
    {1'b0, 2'd2, 13'h060, 32'h0000_BEEF, 4'd2},
    {1'b0, 2'd0, 13'h07C, 32'hFFFF_FFF0, 4'd2},
    {1'b0, 2'd1, 13'h084, 32'h0000_0003, 4'd3},
    {1'b0, 2'd2, 13'h084, 32'h0000_0001, 4'd3},
    {1'b0, 2'd0, 13'h004, 32'h0000_1234, 4'd10},
    {1'b0, 2'd0, 13'h094, 32'h0000_00FF, 4'd10},
    {1'b0, 2'd3, 13'h058, 32'h0000_0777, 4'd1},
    {1'b1, 2'd0, 13'h058, 32'h1000_0040, 4'd2},
    {1'b1, 2'd1, 13'h05C, 32'hA5A5_0004, 4'd2},
    {1'b1, 2'd2, 13'h060, 32'h0000_BEEF, 4'd2},
    {1'b1, 2'd0, 13'h07C, 32'hFFFF_FFF0, 4'd2},
    {1'b1, 2'd1, 13'h058, 32'h0000_0000, 4'd1},
    {1'b1, 2'd1, 13'h084, 32'h0000_0003, 4'd3},
    {1'b1, 2'd2, 13'h084, 32'h0000_0001, 4'd3},
    {1'b1, 2'd0, 13'h004, 32'h0000_0000, 4'd10},
    {1'b1, 2'd0, 13'h094, 32'h0000_0000, 4'd10},
    {1'b1, 2'd3, 13'h058, 32'h0000_0000, 4'd1},
    {1'b1, 2'd0, 13'h090, 32'h0000_0000, 4'd7}
  };

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    rd(0, 13'h084, d); check("R11 cfg", d, 0);
    rd(2, 13'h058, d); check("R11 ptr", d, 0);
    check("R11 irq/pulses", {irq, req_load_d, req_start, req_load_c, req_cont}, 0);

    // Vector walk (R1 R2 R3 R7 R10)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][51]) begin
        rd(int'(VEC[i][50:49]), VEC[i][48:36], d);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), d, VEC[i][35:4]);
      end else
        wr(int'(VEC[i][50:49]), VEC[i][48:36], VEC[i][35:4]);
    end
    check("R3 cfg_en", 32'(cfg_en), 32'b110);
    check("R3 cfg_stop", 32'(cfg_stop), 32'b010);
    check("R2 ptr_data out", ptr_data[31:0], 32'h1000_0040);
    check("R2 ptr_buf out", ptr_buf[63:32], 32'hA5A5_0004);

    // R4: status packing, write ignored
    eng_state[5:3] = 3'd4; eng_eol[1] = 1'b1; eng_src[15:8] = 8'h5A;
    wr(1, 13'h088, 32'hFFFF_FFFF);
    rd(1, 13'h088, d); check("R4 status", d, 32'h0000_5A24);
    eng_state[2:0] = 3'd2;
    rd(0, 13'h088, d); check("R4 status stopped", d, 32'h0000_0002);

    // R5: continue pulse
    wr(0, 13'h080, 32'h1);
    check("R5 cont pulse", 32'(req_cont), 32'b001);
    check("R5 no other", 32'({req_load_d, req_start, req_load_c}), 0);
    @(negedge clk); check("R5 one cycle", 32'(req_cont), 0);
    rd(0, 13'h080, d); check("R5 readback", d, 1);

    // R6: stream decoding
    wr(2, 13'h09C, 32'h160);
    check("R6 load_d+start", 32'({req_load_d, req_start, req_load_c}), {3'b100, 3'b100, 3'b000});
    @(negedge clk); check("R6 one cycle", 32'({req_load_d, req_start}), 0);
    wr(1, 13'h09C, 32'h200);
    check("R6 load_c", 32'({req_load_d, req_start, req_load_c}), {3'b000, 3'b000, 3'b010});
    wr(0, 13'h09C, 32'h040);
    check("R6 load_d only", 32'({req_load_d, req_start, req_load_c}), {3'b001, 3'b000, 3'b000});
    wr(0, 13'h09C, 32'h420);
    check("R6 upper ignored", 32'({req_load_d, req_start, req_load_c}), 0);
    rd(0, 13'h09C, d); check("R6 readback", d, 32'h420);

    // R7 / R9: pending, mask, acknowledge
    @(negedge clk); irq_set[7:0] = 8'h05;
    @(negedge clk); irq_set[7:0] = 8'h00;
    rd(0, 13'h094, d); check("R7 raw set", d, 32'h05);
    check("R9 irq masked off", 32'(irq), 0);
    wr(0, 13'h08C, 32'h04);
    check("R9 irq on", 32'(irq), 32'b001);
    rd(0, 13'h098, d); check("R9 masked", d, 32'h04);
    wr(0, 13'h090, 32'h04);
    rd(0, 13'h094, d); check("R7 ack clears", d, 32'h01);
    check("R9 irq off", 32'(irq), 0);
    wr(0, 13'h08C, 32'h01);
    rd(0, 13'h094, d); check("R7 mask write keeps raw", d, 32'h01);
    check("R9 irq again", 32'(irq), 32'b001);
    rd(0, 13'h08C, d); check("R9 mask readback", d, 32'h01);

    // R8: set beats acknowledge
    @(negedge clk);
    irq_set[7:0] = 8'h02; wr_en = 1'b1; addr = {2'd0, 13'h090}; wdata = 32'h03;
    @(negedge clk);
    irq_set[7:0] = 8'h00; wr_en = 1'b0;
    rd(0, 13'h094, d); check("R8 set wins", d, 32'h02);
    rd(0, 13'h098, d); check("R9 masked after", d, 32'h00);
    check("R9 irq low", 32'(irq), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule